// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous request stream and an external asynchronous static RAM organised as 16-bit words with a separate strobe for each byte. One request at a time is taken in over a valid/ready handshake. Each request is a read or a write and carries a word address, write data and a two-bit lane mask. The block then runs the memory's strobes through a fixed sequence of phases. Every phase lasts a whole number of system clocks. Each count is the ceiling of a nanosecond limit divided by the clock period, so changing the clock period or the speed grade is a parameter change only.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until every strobe of that access is inactive again. A master may hold `req_valid` high with stable fields for any number of cycles. Read results leave on a one-cycle `rsp_valid` pulse that cannot be stalled, so the receiver must always accept it.

Writes end by raising write enable while chip select is still low. The data pad driver is enabled only during the write-enable-low window. A read that is followed directly by a write gets an idle gap in which the memory's output stage can float before the controller drives the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every memory strobe (`mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n`, `mem_ub_n`) is high, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only when no access is in progress, and then every strobe is inactive. A request is taken on an edge with `req_valid` and `req_ready` both high. `req_ready` stays 0 from that edge until the access's last phase ends.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for RD_CYC clocks, with the address unchanged. RD_CYC is the larger of ceil(70 ns / clock) and ceil(35 ns / clock), which is 7 at 10 ns. The data bus is sampled at the edge that ends the last of those clocks.
- R4: Mask bit 0 selects the low lane, driving `mem_lb_n` low and covering data bits 7:0. Mask bit 1 selects the high lane, driving `mem_ub_n` low and covering bits 15:8. On a read, a lane whose mask bit is 0 is returned as zero.
- R5: Each read gives exactly one `rsp_valid` cycle. It is the cycle right after the read phase, which is the cycle in which `req_ready` returns, RD_CYC+1 clocks after acceptance. A write never raises `rsp_valid`.
- R6: A write runs in three parts. First comes one setup clock with `mem_cs_n` low and `mem_we_n` high. Then `mem_we_n` is low for WP_CYC clocks, where WP_CYC is the largest of ceil(55 ns), ceil(30 ns) and ceil(60 ns) - 1, counted in clocks (6 at 10 ns). Finally `mem_we_n` rises while `mem_cs_n` stays low for REC_CYC clocks, where REC_CYC = max(1, ceil(70 ns) - 1 - WP_CYC). `req_ready` returns 2 + WP_CYC + REC_CYC clocks after acceptance.
- R7: A write changes only the lanes whose mask bit is 1. The other lane of the addressed word keeps its old contents.
- R8: `mem_dq_oe` is 1 only while `mem_we_n` and `mem_cs_n` are low and `mem_oe_n` is high. Output enable and the pad driver are never active together.
- R9: When a write is accepted and the previous access was a read, the write first spends TA_CYC = max(1, ceil(25 ns / clock) - 2) clocks with all strobes inactive. As a result, `mem_dq_oe` rises at least ceil(25 ns / clock) clocks after `mem_oe_n` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_mask | input | 2 | Lane select: bit 0 low lane, bit 1 high lane |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 2*LANE_W | Read data, deselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low-lane strobe, active low |
| mem_ub_n | output | 1 | High-lane strobe, active low |
| mem_dq_out | output | 2*LANE_W | Data toward the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 2*LANE_W | Data from the pad |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that the pad input is used only as read data, so they constrain neither its value nor its timing. They assume nothing about how long a master holds `req_valid`.

The bench drives requests at falling edges and keeps them until they are taken. It places writes directly behind reads so that the turnaround gap is at its shortest. Its memory model returns a poison word until enough clocks of stable address and output enable have passed. It records a violation whenever a write pulse is short, a pulse ends by chip select instead of write enable, or the pad driver and output enable overlap.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSET,
    ST_WPULSE,
    ST_WREC
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state_d,
  input  logic [1:0] mask_d,
  output logic       cs_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       lb_n,
  output logic       ub_n,
  output logic       dq_oe
);
  logic in_access;

  always_comb begin
    in_access = (state_d == ST_RD) || (state_d == ST_WSET) ||
                (state_d == ST_WPULSE) || (state_d == ST_WREC);
  end

  // Strobes leave flops so the pins never glitch on state decode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      lb_n  <= 1'b1;
      ub_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      cs_n  <= !in_access;
      oe_n  <= (state_d != ST_RD);
      we_n  <= (state_d != ST_WPULSE);
      lb_n  <= !(in_access && mask_d[0]);
      ub_n  <= !(in_access && mask_d[1]);
      dq_oe <= (state_d == ST_WPULSE);
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [1:0]          mask,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] rdata,
  output logic                rsp_valid
);
  logic [LANE_W-1:0] lane_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)       lane_q[g] <= '0;
      else if (capture) lane_q[g] <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= capture;
  end

  assign rdata = {lane_q[1], lane_q[0]};
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int LANE_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_OHZ_NS  = 25,
  parameter int T_WC_NS   = 70,
  parameter int T_AW_NS   = 60,
  parameter int T_WP_NS   = 55,
  parameter int T_DW_NS   = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_mask,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);
  localparam int DATA_W  = 2 * LANE_W;
  localparam int RD_CYC  = imax(ceil_div(T_AA_NS, CLK_NS), ceil_div(T_OE_NS, CLK_NS));
  localparam int WP_CYC  = imax(imax(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DW_NS, CLK_NS)),
                                ceil_div(T_AW_NS, CLK_NS) - 1);
  localparam int REC_CYC = imax(1, ceil_div(T_WC_NS, CLK_NS) - 1 - WP_CYC);
  localparam int OHZ_CYC = ceil_div(T_OHZ_NS, CLK_NS);
  localparam int TA_CYC  = imax(1, OHZ_CYC - 2);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t        state_q, state_d;
  logic              phase_last;
  logic              accept;
  logic              after_read_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q, mask_d;
  logic [CNT_W-1:0]  phase_len;
  logic              capture;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign mask_d    = accept ? req_mask : mask_q;
  assign capture   = (state_q == ST_RD) && phase_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = !req_write ? ST_RD :
                                          (after_read_q ? ST_TURN : ST_WSET);
      ST_TURN:   if (phase_last) state_d = ST_WSET;
      ST_WSET:   state_d = ST_WPULSE;
      ST_WPULSE: if (phase_last) state_d = ST_WREC;
      ST_WREC:   if (phase_last) state_d = ST_IDLE;
      ST_RD:     if (phase_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_RD:     phase_len = CNT_W'(RD_CYC - 1);
      ST_TURN:   phase_len = CNT_W'(TA_CYC - 1);
      ST_WPULSE: phase_len = CNT_W'(WP_CYC - 1);
      ST_WREC:   phase_len = CNT_W'(REC_CYC - 1);
      default:   phase_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      after_read_q <= 1'b0;
      addr_q       <= '0;
      wdata_q      <= '0;
      mask_q       <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        after_read_q <= !req_write;
        addr_q       <= req_addr;
        wdata_q      <= req_wdata;
        mask_q       <= req_mask;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_d != state_q),
    .load_val (phase_len),
    .last     (phase_last)
  );

  sram_strobe_gen u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .mask_d  (mask_d),
    .cs_n    (mem_cs_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .lb_n    (mem_lb_n),
    .ub_n    (mem_ub_n),
    .dq_oe   (mem_dq_oe)
  );

  sram_rd_capture #(.LANE_W(LANE_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .mask      (mask_q),
    .dq_in     (mem_dq_in),
    .rdata     (rsp_rdata),
    .rsp_valid (rsp_valid)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W   = 18,
  parameter int WP_CYC   = 6,
  parameter int TURN_GAP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  logic [7:0] pulse_cnt;
  logic [7:0] gap_cnt;
  logic       oe_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      gap_cnt   <= 8'hFF;
      oe_n_q    <= 1'b1;
    end else begin
      oe_n_q <= mem_oe_n;
      if (!mem_we_n && !mem_cs_n) pulse_cnt <= (pulse_cnt == 8'hFF) ? pulse_cnt : pulse_cnt + 1'b1;
      else                        pulse_cnt <= '0;
      if (mem_oe_n && !oe_n_q)    gap_cnt <= 8'd1;
      else if (gap_cnt != 8'hFF)  gap_cnt <= gap_cnt + 1'b1;
    end
  end

  a_r8_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_oe_n));

  a_r6_cs_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs_n);

  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (pulse_cnt >= 8'(WP_CYC)));

  a_r2_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_cnt >= 8'(TURN_GAP)));

  a_r4_lanes_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_lb_n && mem_ub_n));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .WP_CYC   (WP_CYC),
  .TURN_GAP (OHZ_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int CLK = 10;
  // Cycle counts from the nanosecond limits of R3, R6, R9.
  localparam int RD_EXP  = ((70 + CLK - 1) / CLK > (35 + CLK - 1) / CLK) ? (70 + CLK - 1) / CLK : (35 + CLK - 1) / CLK;
  localparam int WP_EXP  = 6;
  localparam int REC_EXP = 1;
  localparam int GAP_EXP = (25 + CLK - 1) / CLK;
  localparam int TA_EXP  = (GAP_EXP - 2 > 1) ? GAP_EXP - 2 : 1;
  localparam int WP_MIN  = (55 + CLK - 1) / CLK;
  localparam int RD_MIN  = RD_EXP - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic cs_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [15:0] dq_out, dq_in;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(AW)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(cs_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_lb_n(lb_n), .mem_ub_n(ub_n), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe),
    .mem_dq_in(dq_in));

  int n_tests = 0, n_fail = 0;
  int wp_err = 0, csend_err = 0, drive_err = 0, cont_err = 0, turn_err = 0, turn_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model
  logic [15:0] mem [DEPTH];
  logic [15:0] shadow [DEPTH];
  int rcnt = 0;
  logic [AW-1:0] r_addr = '0;
  int wcnt = 0;
  bit wlive = 0;
  logic [15:0] wd = '0;
  logic [AW-1:0] wa = '0;
  bit wlb = 0, wub = 0;

  wire rd_act = !cs_n && !oe_n && we_n;
  assign dq_in = rd_act ? ((rcnt >= RD_MIN) ?
                   {!ub_n ? mem[mem_addr][15:8] : 8'hEE, !lb_n ? mem[mem_addr][7:0] : 8'hEE}
                   : 16'hBAD0) : 16'h5A5A;

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= 0; wcnt <= 0; wlive <= 0;
    end else begin
      if (rd_act && (rcnt == 0 || mem_addr == r_addr)) begin
        rcnt <= rcnt + 1; r_addr <= mem_addr;
      end else rcnt <= 0;
      if (!cs_n && !we_n) begin
        wlive <= 1; wcnt <= wcnt + 1; wd <= dq_out; wa <= mem_addr;
        wlb <= !lb_n; wub <= !ub_n;
        if (!dq_oe) drive_err++;
        if (!oe_n) cont_err++;
      end else begin
        if (wlive) begin
          if (wcnt < WP_MIN) wp_err++;
          if (cs_n) csend_err++;
          if (wlb) mem[wa][7:0] <= wd[7:0];
          if (wub) mem[wa][15:8] <= wd[15:8];
        end
        wlive <= 0; wcnt <= 0;
      end
      if (dq_oe && we_n) drive_err++;
    end
  end

  // Turnaround observer, sampled away from the edge (R9)
  int cyc = 0, oe_rise_cyc = -100;
  logic oe_prev = 1, dq_prev = 0;
  bit pending = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (oe_n && !oe_prev) begin oe_rise_cyc = cyc; pending = 1; end
      if (dq_oe && !dq_prev && pending) begin
        turn_seen++;
        if (cyc - oe_rise_cyc < GAP_EXP) turn_err++;
        pending = 0;
      end
    end
    oe_prev = oe_n; dq_prev = dq_oe;
  end

  bit last_rd = 0;

  // Called at a falling edge; returns at the falling edge where ready is back.
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string req, input logic [15:0] exp_rd);
    int n;
    int exp_n;
    bit early_rsp;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1; early_rsp = 0;
    while (!req_ready && n < 40) begin
      if (rsp_valid) early_rsp = 1;
      @(negedge clk);
      n++;
    end
    check(!early_rsp, "R5", "rsp_valid before read end", early_rsp, 0);
    if (wr) begin
      exp_n = 2 + WP_EXP + REC_EXP + (last_rd ? TA_EXP : 0);
      check(n == exp_n, last_rd ? "R9" : "R6", "write busy cycles", n, exp_n);
      check(!rsp_valid, "R5", "rsp_valid on write", rsp_valid, 0);
    end else begin
      check(n == RD_EXP + 1, "R3", "read busy cycles", n, RD_EXP + 1);
      check(rsp_valid, "R5", "rsp_valid at read end", rsp_valid, 1);
      check(rsp_rdata == exp_rd, req, "read data", rsp_rdata, exp_rd);
    end
    last_rd = !wr;
  endtask

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] v,
                                        input logic [1:0] m);
    return {m[1] ? v[15:8] : old[15:8], m[0] ? v[7:0] : old[7:0]};
  endfunction

  bit done = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    check({cs_n, oe_n, we_n, lb_n, ub_n} == 5'h1F, "R1", "strobes in reset", {cs_n, oe_n, we_n, lb_n, ub_n}, 5'h1F);
    rst_n = 1;
    @(negedge clk);
    check({cs_n, oe_n, we_n, lb_n, ub_n} == 5'h1F, "R1", "strobes after reset", {cs_n, oe_n, we_n, lb_n, ub_n}, 5'h1F);
    check(!dq_oe && req_ready && !rsp_valid, "R1", "oe/ready/valid after reset",
          {dq_oe, req_ready, rsp_valid}, 3'b010);

    // Pass 1: full-word writes to every address (R6)
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] v;
      v = 16'hA500 ^ 16'(a * 16'h0137);
      do_op(1, AW'(a), v, 2'b11, "R6", '0);
      shadow[a] = v;
    end
    // Pass 2: single-lane writes alternate lanes (R7)
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] v;
      logic [1:0] m;
      v = ~(16'h1F00 + 16'(a * 16'h0301));
      m = a[0] ? 2'b01 : 2'b10;
      do_op(1, AW'(a), v, m, "R7", '0);
      shadow[a] = merge(shadow[a], v, m);
    end
    // Pass 3: reads with every mask pattern (R3, R4, R7)
    for (int a = 0; a < DEPTH; a++) begin
      logic [1:0] m;
      m = 2'(a);
      do_op(0, AW'(a), '0, m, (m == 2'b11) ? "R7" : "R4", masked(shadow[a], m));
    end
    // Pass 4: read-write-read back to back for turnaround (R9, R8, R7)
    for (int a = 0; a < 16; a++) begin
      logic [15:0] v;
      logic [1:0] m;
      v = 16'(a * 16'h1111) ^ 16'h00FF;
      m = 2'(a % 3 + 1);
      do_op(0, AW'(a), '0, 2'b11, "R3", shadow[a]);
      do_op(1, AW'(a), v, m, "R9", '0);
      shadow[a] = merge(shadow[a], v, m);
      do_op(0, AW'(a), '0, 2'b11, "R7", shadow[a]);
    end
    // Held valid while busy: the second request waits for ready (R2)
    req_valid = 1; req_write = 1; req_addr = 6'd40; req_wdata = 16'hC3C3; req_mask = 2'b11;
    @(negedge clk);
    check(!req_ready, "R2", "ready low while busy", req_ready, 0);
    req_addr = 6'd41;
    while (!req_ready) @(negedge clk);
    shadow[40] = 16'hC3C3;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    shadow[41] = 16'hC3C3;
    last_rd = 0;
    do_op(0, 6'd40, '0, 2'b11, "R2", shadow[40]);
    do_op(0, 6'd41, '0, 2'b11, "R2", shadow[41]);

    check(wp_err == 0, "R6", "short write pulses", wp_err, 0);
    check(csend_err == 0, "R6", "write ended by chip select", csend_err, 0);
    check(drive_err == 0, "R8", "pad drive outside pulse", drive_err, 0);
    check(cont_err == 0, "R8", "drive with output enable", cont_err, 0);
    check(turn_seen > 0, "R9", "turnarounds observed", turn_seen, 16);
    check(turn_err == 0, "R9", "short turnaround gaps", turn_err, 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule